// File: doc/BRIEF.md
# PWM Timer with Double-Buffered Compare Values

This block is a programmable timer that doubles as a multi-channel, single-edge PWM generator. An enabled prescaler divides the clock, and each prescaler wrap advances a timer count. A bank of compare channels watches that count. Channel 0 sets the PWM period, and channels 1 and up each drive one PWM output that is high from the start of a period until the count reaches that channel's compare value. Every compare channel sets a sticky interrupt flag on a match.

Software programs the block through a single-cycle register write strobe. No write is ever refused, so there is no back-pressure: each strobe with `wr_en` high is taken on that clock edge. In PWM mode, a compare write first lands in a shadow copy. It moves to the live comparator only after software arms that channel's latch bit and a period event (a channel 0 match) then occurs. The latch bit clears itself on that event. In timer mode, compare writes go live at once. The mode also picks the value the count restarts from: 1 in PWM mode and 0 in timer mode.

Top module: `pwmt_timer`

## Requirements
- R1: While control bit 0 (enable) is clear and control bit 1 is clear, `count` and the prescaler hold their values.
- R2: While control bit 1 (counter reset) is set, `count` is forced to 1 if control bit 3 (PWM mode) is set and to 0 otherwise, and the prescaler is forced to 0. This starts on the first edge after the control write and lasts until the bit is cleared.
- R3: When enabled with prescale value P (register word 2), `count` advances by one every P+1 clock cycles. The prescaler wraps to 0 on the cycle that advances the count.
- R4: In PWM mode, an advance taken while `count` equals live compare 0 reloads `count` to 1 (a period event). The period is therefore compare-0 advances.
- R5: In timer mode, a write to compare register n (word 4+n) takes effect on the next edge, without any latch step.
- R6: In PWM mode, a compare write goes live only after its latch bit (word 3, bit n, where writing 1 arms and writing 0 has no effect) is armed and a later period event occurs. Armed latch bits clear on that event.
- R7: In PWM mode, a compare write with no armed latch bit leaves the live value unchanged, even across period events.
- R8: An advance taken while `count` equals live compare n sets `irq_flags[n]`. Writing 1 to bit n of word 0 clears the flag. If a set and a clear arrive on the same edge, the set wins.
- R9: In PWM mode, `pwm_out[n-1]` (channel n) goes high on a period event and while the counter is held in reset. It goes low on the advance taken at `count` equal to live compare n, and a period event on the same edge takes priority. In timer mode all outputs are 0.
- R10: Control bit 2 and bits 31:4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, accepted every cycle |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| count | output | CNT_W | Timer count value |
| pwm_out | output | NUM_CH-1 | PWM outputs; bit i belongs to channel i+1 |
| irq_flags | output | NUM_CH | Sticky match flags; bit n belongs to channel n |

## Verification
The bench builds the block with a 16-bit count, an 8-bit prescaler and four compare channels, which gives three PWM outputs. With these sizes a short period of 8 and small compare values are enough to cover full periods, output edges and several period events within a few hundred cycles. A prescale value of 2 exercises the divide-by-three step. Because the PWM phase is known from the cycle of the enable write, the bench can pick sample points at exact count values. Those points show whether a shadowed value has gone live and whether a latch bit has cleared itself.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  // register word addresses
  localparam int unsigned REG_IRQ        = 0;
  localparam int unsigned REG_CTRL       = 1;
  localparam int unsigned REG_PRESCALE   = 2;
  localparam int unsigned REG_LATCH      = 3;
  localparam int unsigned REG_MATCH_BASE = 4;
  // control bit positions
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_RST_BIT = 1;
  localparam int unsigned CTRL_PWM_BIT = 3;

  typedef struct packed {
    logic pwm;
    logic rst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int unsigned PS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] limit,
  output logic            tick
);
  logic [PS_W-1:0] pc_q;
  logic            wrap;

  assign wrap = (pc_q >= limit);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (clr) begin
      pc_q <= '0;
    end else if (run) begin
      pc_q <= wrap ? '0 : pc_q + PS_W'(1);
    end
  end
endmodule

// File: rtl/pwmt_match_bank.sv
module pwmt_match_bank
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              tick,
  output logic [NUM_CH-1:0] match_evt,
  output logic              period_evt,
  output logic [NUM_CH-1:0] latch_en
);
  logic [NUM_CH-1:0] le_q;
  logic              latch_wr;
  logic [NUM_CH-1:0] le_keep;
  logic [NUM_CH-1:0] le_set;

  assign latch_wr   = wr_en && (wr_addr == ADDR_W'(REG_LATCH));
  assign period_evt = pwm_mode && match_evt[0];
  assign le_keep    = period_evt ? '0 : le_q;
  assign le_set     = latch_wr ? wr_data[NUM_CH-1:0] : '0;
  assign latch_en   = le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) le_q <= '0;
    else        le_q <= le_keep | le_set;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             sel;

    assign sel          = wr_en && (wr_addr == ADDR_W'(REG_MATCH_BASE + n));
    assign match_evt[n] = tick && (count == active_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q <= '0;
        active_q <= '0;
      end else begin
        if (sel) shadow_q <= wr_data[CNT_W-1:0];
        if (!pwm_mode && sel)          active_q <= wr_data[CNT_W-1:0];
        else if (period_evt && le_q[n]) active_q <= shadow_q;
      end
    end
  end
endmodule

// File: rtl/pwmt_out_stage.sv
module pwmt_out_stage #(
  parameter int unsigned NUM_OUT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwm_mode,
  input  logic               hold_high,
  input  logic               period_evt,
  input  logic [NUM_OUT-1:0] clr_evt,
  output logic [NUM_OUT-1:0] pwm_out
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       out_q <= 1'b0;
      else if (!pwm_mode)               out_q <= 1'b0;
      else if (hold_high || period_evt) out_q <= 1'b1;
      else if (clr_evt[i])              out_q <= 1'b0;
    end
    assign pwm_out[i] = out_q;
  end
endmodule

// File: rtl/pwmt_timer.sv
module pwmt_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned PS_W   = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [NUM_CH-2:0] pwm_out,
  output logic [NUM_CH-1:0] irq_flags
);
  localparam int unsigned NUM_OUT = NUM_CH - 1;

  ctrl_t             ctrl_q;
  logic [PS_W-1:0]   presc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_rst_val;
  logic [NUM_CH-1:0] flags_q;
  logic [NUM_CH-1:0] flag_clr;
  logic [NUM_CH-1:0] match_evt;
  logic [NUM_CH-1:0] latch_en;
  logic              period_evt;
  logic              tick;
  logic              run;
  logic              ctrl_wr;

  assign ctrl_wr     = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign run         = ctrl_q.en && !ctrl_q.rst;
  assign cnt_rst_val = ctrl_q.pwm ? CNT_W'(1) : '0;
  assign flag_clr    = (wr_en && (wr_addr == ADDR_W'(REG_IRQ))) ? wr_data[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en  <= wr_data[CTRL_EN_BIT];
        ctrl_q.rst <= wr_data[CTRL_RST_BIT];
        ctrl_q.pwm <= wr_data[CTRL_PWM_BIT];
      end
      if (wr_en && (wr_addr == ADDR_W'(REG_PRESCALE))) presc_q <= wr_data[PS_W-1:0];
    end
  end

  pwmt_prescaler #(.PS_W(PS_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .clr   (ctrl_q.rst),
    .limit (presc_q),
    .tick  (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (ctrl_q.rst) cnt_q <= cnt_rst_val;
    else if (tick)       cnt_q <= period_evt ? CNT_W'(1) : cnt_q + CNT_W'(1);
  end

  pwmt_match_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_mode   (ctrl_q.pwm),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .count      (cnt_q),
    .tick       (tick),
    .match_evt  (match_evt),
    .period_evt (period_evt),
    .latch_en   (latch_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~flag_clr) | match_evt;
  end

  pwmt_out_stage #(.NUM_OUT(NUM_OUT)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_mode   (ctrl_q.pwm),
    .hold_high  (ctrl_q.rst),
    .period_evt (period_evt),
    .clr_evt    (match_evt[NUM_CH-1:1]),
    .pwm_out    (pwm_out)
  );

  assign count     = cnt_q;
  assign irq_flags = flags_q;
endmodule

// File: rtl/pwmt_timer_chk.sv
module pwmt_timer_chk
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 7,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_en,
  input logic              ctrl_rst,
  input logic              ctrl_pwm,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  count,
  input logic              period_evt,
  input logic [NUM_CH-1:0] match_evt,
  input logic [NUM_CH-1:0] latch_en,
  input logic [NUM_CH-2:0] pwm_out,
  input logic [NUM_CH-1:0] irq_flags
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !ctrl_rst) |=> $stable(count)); // R1
  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst |=> (count == CNT_W'($past(ctrl_pwm)))); // R2
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> (count == CNT_W'(1))); // R4
  AST_LATCH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (period_evt && !(wr_en && wr_addr == ADDR_W'(REG_LATCH))) |=> (latch_en == '0)); // R6
  AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_evt) |=> ((irq_flags & $past(match_evt)) == $past(match_evt))); // R8
  AST_TIMER_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_pwm |=> (pwm_out == '0)); // R9
endmodule

bind pwmt_timer pwmt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_en    (ctrl_q.en),
  .ctrl_rst   (ctrl_q.rst),
  .ctrl_pwm   (ctrl_q.pwm),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .count      (cnt_q),
  .period_evt (period_evt),
  .match_evt  (match_evt),
  .latch_en   (latch_en),
  .pwm_out    (pwm_out),
  .irq_flags  (irq_flags)
);

// File: tb/tb_pwmt_timer.sv
module tb_pwmt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 8;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic [CNT_W-1:0]  count;
  logic [NUM_CH-2:0] pwm_out;
  logic [NUM_CH-1:0] irq_flags;

  pwmt_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pwm_out(pwm_out), .irq_flags(irq_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    due;
    int    sel;   // 0 count, 1 pwm_out, 2 irq_flags
    int    exp;
    string req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int pwm_x = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items when due and compares
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      int act;
      it = sb.pop_front();
      case (it.sel)
        0: act = int'(count);
        1: act = int'(pwm_out);
        default: act = int'(irq_flags);
      endcase
      n_checks++;
      if (it.due != cyc) begin
        n_fail++;
        $display("FAIL %s: sample missed at cycle %0d (due %0d) actual %0d expected %0d",
                 it.req, cyc, it.due, act, it.exp);
      end else if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s: sel %0d at cycle %0d actual %0d expected %0d",
                 it.req, it.sel, cyc, act, it.exp);
      end
    end
  end

  task automatic push(input int due, input int sel, input int exp, input string req);
    item_t it;
    it.due = due; it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // count value in PWM phase with period 8, started at cycle pwm_x
  function automatic int cnt_at(input int t);
    return ((t - pwm_x) % 8) + 1;
  endfunction

  function automatic int first_at(input int after, input int val);
    for (int t = after; t < after + 64; t++) if (cnt_at(t) == val) return t;
    return after;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    int x;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push(cyc + 1, 0, 0, "R2 reset count");
    push(cyc + 1, 1, 0, "R9 reset outputs");
    push(cyc + 1, 2, 0, "R8 reset flags");
    drain();

    // park all compares far away (timer mode: immediate)
    for (int n = 0; n < NUM_CH; n++) wr(4 + n, 32'd1000);

    // R1: disabled counter holds
    wr(1, 32'h0); x = cyc;
    push(x + 4, 0, 0, "R1 disabled holds zero");
    drain();

    // R10: reserved bits set alongside enable, timer mode
    wr(1, 32'hFFFF_FFF5); x = cyc;
    push(x + 5, 0, 5, "R10 reserved bits ignored, counting");
    push(x + 5, 1, 0, "R10 timer mode outputs low");
    drain();
    wr(1, 32'h0); x = cyc;
    t = x - (x - 0);
    push(x + 3, 0, int'(count), "R1 hold after disable");
    drain();

    // R2: reset bit holds timer reset value 0
    wr(1, 32'h3); x = cyc;
    push(x + 2, 0, 0, "R2 timer reset value");
    push(x + 4, 0, 0, "R2 held in reset");
    drain();

    // R3: prescale 2 -> one advance every three cycles
    wr(2, 32'd2);
    wr(1, 32'h1); x = cyc;
    push(x + 2, 0, 0, "R3 prescale before wrap");
    push(x + 3, 0, 1, "R3 prescale first advance");
    push(x + 8, 0, 2, "R3 prescale second advance");
    push(x + 9, 0, 3, "R3 prescale third advance");
    drain();

    // R5/R8: timer mode compare immediate, flag sticky, write-1 clear
    wr(2, 32'd0);
    wr(5, 32'd10);
    wr(1, 32'h3);
    wr(0, 32'hF);
    wr(1, 32'h1); x = cyc;
    push(x + 10, 2, 0, "R8 flag clear before match");
    push(x + 11, 2, 2, "R5 immediate compare sets flag 1");
    push(x + 14, 2, 2, "R8 flag stays set");
    drain();
    wr(0, 32'h2); x = cyc;
    push(x + 1, 2, 0, "R8 write-one clears flag");
    drain();

    // PWM setup in timer mode: period 8, ch1=3, ch2=6, ch3 never
    wr(4, 32'd8);
    wr(5, 32'd3);
    wr(6, 32'd6);
    wr(1, 32'hA); x = cyc;
    push(x + 2, 0, 1, "R2 PWM reset value one");
    push(x + 2, 1, 7, "R9 outputs high in reset");
    drain();
    wr(1, 32'h9); x = cyc;
    pwm_x = x;
    push(x + 3, 1, 6, "R9 ch1 low after compare 3");
    push(x + 6, 1, 4, "R9 ch2 low after compare 6");
    push(x + 7, 0, 8, "R4 count reaches period");
    push(x + 8, 0, 1, "R4 reload to one");
    push(x + 8, 1, 7, "R9 outputs high at period start");
    push(x + 10, 0, 3, "R4 second period counting");
    drain();

    // R7: shadow write without latch bit has no effect
    wr(5, 32'd5); x = cyc;
    t = first_at(x + 9, 4);
    push(t, 1, 6, "R7 unlatched write not live");
    drain();

    // R6: arm latch bit 1, value goes live after next period event
    wr(3, 32'h2); x = cyc;
    t = first_at(x + 9, 4);
    push(t, 1, 7, "R6 latched compare 5 live");
    drain();

    // R6: latch bit cleared itself, new write stays shadowed
    wr(5, 32'd7); x = cyc;
    t = first_at(x + 9, 6);
    push(t, 1, 6, "R6 latch bit self-cleared");
    drain();

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule